// File: doc/BRIEF.md
# Multicycle 8-bit Accumulator Machine Sequencer

This block is the control core of a small 8-bit machine. It holds an 8-bit program counter, an accumulator, an index register and zero, negative and carry flags. It drives a single-port synchronous byte memory of parameterised size, up to 256 bytes, through registered address, write-data and write-enable outputs and one read-data input. The memory returns data one cycle after it samples the address.

The memory is loaded while the block is idle. A start pulse then begins execution at a chosen address. Each instruction takes several states: opcode fetch, an optional argument fetch, effective address formation, operand read and then execute or write-back. Each state makes at most one memory access. Execution ends on a halt instruction, an undefined opcode, or any attempt to fetch or access a location outside the populated memory. The `halted` output then rises and stays high until reset. The result of a run is the final memory image.

Top module: `acc_seq_cpu`

## Requirements
- R1: After reset `halted` and `mem_we` are low, the accumulator and index register hold zero, and the block does not run or write until `start` is sampled high.
- R2: A `start` pulse while idle loads the program counter from `start_pc` and clears all three flags. The first opcode is fetched from that address, and A and X keep their values.
- R3: The memory-operand instruction families are selected by opcode bits 7:3, and bit 0 must be zero. Bits 2:1 pick the operand location: 00 is the argument byte itself at PC+1, 01 is the address held in the argument, and 10 is the argument plus X as an unsigned sum with no wrap. Family codes: 00 load A, 01 store A, 02 load X, 03 store X, 06 AND, 07 OR, 08 XOR, 09 shift right, 0A shift left, 0B rotate right, 0C rotate left, 0D add with carry, 0F increment memory, 10 decrement memory, 11 compare A, 12 compare X.
- R4: Opcodes C0, C8, C9, D0 and D1 are one byte long. All other instructions are two bytes long, and the PC advances by 1 or 2 when no branch is taken.
- R5: Load, AND, OR, XOR, add with carry, increment and decrement wrap modulo 256. Each sets Z when its result is zero and N to bit 7 of its result. Add with carry sets C to the carry out of bit 7.
- R6: Shift right moves bit 0 into C and fills bit 7 with 0. Shift left moves bit 7 into C and fills bit 0 with 0. The rotates feed the old C into the vacated bit. All four write the result back to the operand location and set Z and N from it.
- R7: The compares compute register minus operand and set Z and N from the difference. They set C when no borrow occurs. No register or memory byte changes.
- R8: C0 halts. C8 and C9 increment and decrement X modulo 256 and set Z and N. D0 sets C and D1 clears C.
- R9: Opcodes F2 to FE (even) branch always, on Z clear, Z set, N clear, N set, C clear and C set, in that order. A taken branch goes to the address of the next instruction plus the sign-extended argument.
- R10: The machine halts, with no further access, when the opcode or argument address is at or beyond the memory size. It does not wrap from 255 to 0.
- R11: The machine halts, with no access, when an effective address is at or beyond the memory size (an indexed sum above 255 included). It also halts when a taken branch target is negative or at or beyond the memory size.
- R12: Any opcode not listed in R3, R4 or R9 halts the machine without changing memory. This includes family codes with bit 0 set or with mode 11.
- R13: Once `halted` is high it stays high, and no memory write occurs until reset, even if `start` is pulsed again.
- R14: Every write is a single-cycle `mem_we` pulse. Write enable is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution when idle |
| start_pc | input | 8 | Address of the first opcode |
| mem_addr | output | 8 | Registered memory address |
| mem_wdata | output | 8 | Registered write data |
| mem_we | output | 1 | Registered write enable |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| halted | output | 1 | Machine stopped |

## Verification
Internal state is visible only through memory traffic and the halt output. A wrong flag or register value shows up when a later store, read-modify-write or branch decision places a different byte in memory, or sends execution down a different path. This usually happens within a few instructions. A wrong range check shows up as a write into a wrapped address, or as a halt that comes too early or too late. The bench therefore builds programs whose final image depends on every flag and on each boundary, and compares the whole memory against an instruction-level model after the halt.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [3:0] {
    ALU_PASS, ALU_AND, ALU_OR, ALU_XOR, ALU_ADC, ALU_LSR, ALU_ASL,
    ALU_ROR, ALU_ROL, ALU_INC, ALU_DEC, ALU_SUB
  } alu_op_e;

  typedef enum logic [1:0] {DST_NONE, DST_A, DST_X, DST_MEM} dst_e;

  typedef enum logic [2:0] {
    K_BAD, K_MEMOP, K_STORE, K_BRANCH, K_HALT, K_INDEX, K_CARRY
  } kind_e;

  typedef struct packed {
    kind_e   kind;
    alu_op_e alu;
    dst_e    dst;
    logic    use_x;
    logic    upd_c;
  } dec_t;

  localparam logic [1:0] MODE_IMM = 2'b00;
  localparam logic [1:0] MODE_ABS = 2'b01;
  localparam logic [1:0] MODE_IDX = 2'b10;

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
(
  input  logic [7:0] opc,
  output dec_t       dec
);
  logic fam_hit;

  always_comb begin
    dec     = '{kind: K_BAD, alu: ALU_PASS, dst: DST_NONE, use_x: 1'b0, upd_c: 1'b0};
    fam_hit = 1'b1;
    case (opc[7:3])
      5'h00: begin dec.kind = K_MEMOP; dec.dst = DST_A; end
      5'h01: begin dec.kind = K_STORE; end
      5'h02: begin dec.kind = K_MEMOP; dec.dst = DST_X; end
      5'h03: begin dec.kind = K_STORE; dec.use_x = 1'b1; end
      5'h06: begin dec.kind = K_MEMOP; dec.dst = DST_A; dec.alu = ALU_AND; end
      5'h07: begin dec.kind = K_MEMOP; dec.dst = DST_A; dec.alu = ALU_OR; end
      5'h08: begin dec.kind = K_MEMOP; dec.dst = DST_A; dec.alu = ALU_XOR; end
      5'h09: begin dec.kind = K_MEMOP; dec.dst = DST_MEM; dec.alu = ALU_LSR; dec.upd_c = 1'b1; end
      5'h0A: begin dec.kind = K_MEMOP; dec.dst = DST_MEM; dec.alu = ALU_ASL; dec.upd_c = 1'b1; end
      5'h0B: begin dec.kind = K_MEMOP; dec.dst = DST_MEM; dec.alu = ALU_ROR; dec.upd_c = 1'b1; end
      5'h0C: begin dec.kind = K_MEMOP; dec.dst = DST_MEM; dec.alu = ALU_ROL; dec.upd_c = 1'b1; end
      5'h0D: begin dec.kind = K_MEMOP; dec.dst = DST_A; dec.alu = ALU_ADC; dec.upd_c = 1'b1; end
      5'h0F: begin dec.kind = K_MEMOP; dec.dst = DST_MEM; dec.alu = ALU_INC; end
      5'h10: begin dec.kind = K_MEMOP; dec.dst = DST_MEM; dec.alu = ALU_DEC; end
      5'h11: begin dec.kind = K_MEMOP; dec.alu = ALU_SUB; dec.upd_c = 1'b1; end
      5'h12: begin dec.kind = K_MEMOP; dec.alu = ALU_SUB; dec.upd_c = 1'b1; dec.use_x = 1'b1; end
      default: begin
        fam_hit = 1'b0;
        if (opc == 8'hC0)                        dec.kind = K_HALT;
        else if (opc == 8'hC8 || opc == 8'hC9)   dec.kind = K_INDEX;
        else if (opc == 8'hD0 || opc == 8'hD1)   dec.kind = K_CARRY;
        else if (opc[7:4] == 4'hF && !opc[0] && opc[3:1] != 3'd0)
                                                 dec.kind = K_BRANCH;
      end
    endcase
    if (fam_hit && (opc[0] || opc[2:1] == 2'b11)) dec.kind = K_BAD;
  end
endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
(
  input  alu_op_e    op,
  input  logic [7:0] lhs,
  input  logic [7:0] rhs,
  input  logic       cin,
  output logic [7:0] res,
  output logic       cout
);
  logic [8:0] wide;

  always_comb begin
    res  = rhs;
    cout = cin;
    wide = 9'd0;
    case (op)
      ALU_PASS: res = rhs;
      ALU_AND:  res = lhs & rhs;
      ALU_OR:   res = lhs | rhs;
      ALU_XOR:  res = lhs ^ rhs;
      ALU_ADC: begin
        wide = {1'b0, lhs} + {1'b0, rhs} + {8'd0, cin};
        res  = wide[7:0];
        cout = wide[8];
      end
      ALU_LSR: begin res = {1'b0, rhs[7:1]}; cout = rhs[0]; end
      ALU_ASL: begin res = {rhs[6:0], 1'b0}; cout = rhs[7]; end
      ALU_ROR: begin res = {cin, rhs[7:1]};  cout = rhs[0]; end
      ALU_ROL: begin res = {rhs[6:0], cin};  cout = rhs[7]; end
      ALU_INC:  res = rhs + 8'd1;
      ALU_DEC:  res = rhs - 8'd1;
      ALU_SUB: begin
        res  = lhs - rhs;
        cout = (lhs >= rhs);
      end
      default: res = rhs;
    endcase
  end
endmodule

// File: rtl/acc_seq_agu.sv
module acc_seq_agu
  import acc_seq_pkg::*;
#(
  parameter int MEM_SIZE = 256
) (
  input  logic [1:0] mode,
  input  logic [8:0] pc,
  input  logic [7:0] arg,
  input  logic [7:0] x,
  output logic [8:0] ea,
  output logic       ea_ok,
  output logic [8:0] tgt,
  output logic       tgt_ok
);
  localparam logic [9:0] MEM_LIM = 10'(MEM_SIZE);

  logic signed [10:0] tsum;

  always_comb begin
    case (mode)
      MODE_IMM: ea = pc + 9'd1;
      MODE_ABS: ea = {1'b0, arg};
      default:  ea = {1'b0, arg} + {1'b0, x};
    endcase
    ea_ok = ({1'b0, ea} < MEM_LIM);

    tsum   = $signed({2'b00, pc}) + 11'sd2 + $signed({{3{arg[7]}}, arg});
    tgt    = tsum[8:0];
    tgt_ok = !tsum[10] && (tsum < $signed({1'b0, MEM_LIM}));
  end
endmodule

// File: rtl/acc_seq_cpu.sv
module acc_seq_cpu
  import acc_seq_pkg::*;
#(
  parameter int MEM_SIZE = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] start_pc,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  input  logic [7:0] mem_rdata,
  output logic       halted
);
  localparam logic [9:0] MEM_LIM = 10'(MEM_SIZE);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_OPW, S_DEC, S_ARGW, S_ARG, S_OPNW, S_EXEC, S_HALT
  } state_e;

  state_e     st_q;
  logic [8:0] pc_q;
  logic [7:0] a_q, x_q, opc_q;
  logic       z_q, n_q, c_q;
  logic [7:0] addr_q, wdata_q;
  logic       we_q, halt_q;

  logic [7:0] dec_in;
  dec_t       dec;
  alu_op_e    alu_op;
  logic [7:0] alu_l, alu_r, alu_res;
  logic       alu_c;
  logic [8:0] ea, tgt, pc_inc1, pc_inc2;
  logic       ea_ok, tgt_ok, take;

  assign dec_in  = (st_q == S_DEC) ? mem_rdata : opc_q;
  assign pc_inc1 = pc_q + 9'd1;
  assign pc_inc2 = pc_q + 9'd2;

  acc_seq_decode u_dec (
    .opc (dec_in),
    .dec (dec)
  );

  always_comb begin
    if (st_q == S_DEC) begin
      alu_op = mem_rdata[0] ? ALU_DEC : ALU_INC;
      alu_r  = x_q;
    end else begin
      alu_op = dec.alu;
      alu_r  = mem_rdata;
    end
    alu_l = dec.use_x ? x_q : a_q;
  end

  acc_seq_alu u_alu (
    .op   (alu_op),
    .lhs  (alu_l),
    .rhs  (alu_r),
    .cin  (c_q),
    .res  (alu_res),
    .cout (alu_c)
  );

  acc_seq_agu #(.MEM_SIZE(MEM_SIZE)) u_agu (
    .mode   (dec_in[2:1]),
    .pc     (pc_q),
    .arg    (mem_rdata),
    .x      (x_q),
    .ea     (ea),
    .ea_ok  (ea_ok),
    .tgt    (tgt),
    .tgt_ok (tgt_ok)
  );

  always_comb begin
    case (dec_in[3:1])
      3'd1:    take = 1'b1;
      3'd2:    take = !z_q;
      3'd3:    take = z_q;
      3'd4:    take = !n_q;
      3'd5:    take = n_q;
      3'd6:    take = !c_q;
      3'd7:    take = c_q;
      default: take = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      pc_q    <= 9'd0;
      a_q     <= 8'd0;
      x_q     <= 8'd0;
      opc_q   <= 8'd0;
      z_q     <= 1'b0;
      n_q     <= 1'b0;
      c_q     <= 1'b0;
      addr_q  <= 8'd0;
      wdata_q <= 8'd0;
      we_q    <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start) begin
            pc_q <= {1'b0, start_pc};
            z_q  <= 1'b0;
            n_q  <= 1'b0;
            c_q  <= 1'b0;
            st_q <= S_FETCH;
          end
        end
        S_FETCH: begin
          if ({1'b0, pc_q} < MEM_LIM) begin
            addr_q <= pc_q[7:0];
            st_q   <= S_OPW;
          end else begin
            st_q   <= S_HALT;
            halt_q <= 1'b1;
          end
        end
        S_OPW: st_q <= S_DEC;
        S_DEC: begin
          opc_q <= mem_rdata;
          case (dec.kind)
            K_INDEX: begin
              x_q  <= alu_res;
              z_q  <= (alu_res == 8'd0);
              n_q  <= alu_res[7];
              pc_q <= pc_inc1;
              st_q <= S_FETCH;
            end
            K_CARRY: begin
              c_q  <= ~mem_rdata[0];
              pc_q <= pc_inc1;
              st_q <= S_FETCH;
            end
            K_MEMOP, K_STORE, K_BRANCH: begin
              if ({1'b0, pc_inc1} < MEM_LIM) begin
                addr_q <= pc_inc1[7:0];
                st_q   <= S_ARGW;
              end else begin
                st_q   <= S_HALT;
                halt_q <= 1'b1;
              end
            end
            default: begin
              st_q   <= S_HALT;
              halt_q <= 1'b1;
            end
          endcase
        end
        S_ARGW: st_q <= S_ARG;
        S_ARG: begin
          if (dec.kind == K_BRANCH) begin
            if (!take) begin
              pc_q <= pc_inc2;
              st_q <= S_FETCH;
            end else if (tgt_ok) begin
              pc_q <= tgt;
              st_q <= S_FETCH;
            end else begin
              st_q   <= S_HALT;
              halt_q <= 1'b1;
            end
          end else if (!ea_ok) begin
            st_q   <= S_HALT;
            halt_q <= 1'b1;
          end else if (dec.kind == K_STORE) begin
            addr_q  <= ea[7:0];
            wdata_q <= dec.use_x ? x_q : a_q;
            we_q    <= 1'b1;
            pc_q    <= pc_inc2;
            st_q    <= S_FETCH;
          end else begin
            addr_q <= ea[7:0];
            st_q   <= S_OPNW;
          end
        end
        S_OPNW: st_q <= S_EXEC;
        S_EXEC: begin
          case (dec.dst)
            DST_A:   a_q <= alu_res;
            DST_X:   x_q <= alu_res;
            DST_MEM: begin
              wdata_q <= alu_res;
              we_q    <= 1'b1;
            end
            default: ;
          endcase
          z_q <= (alu_res == 8'd0);
          n_q <= alu_res[7];
          if (dec.upd_c) c_q <= alu_c;
          pc_q <= pc_inc2;
          st_q <= S_FETCH;
        end
        default: st_q <= S_HALT;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_we    = we_q;
  assign halted    = halt_q;

endmodule

// File: rtl/acc_seq_cpu_chk.sv
module acc_seq_cpu_chk (
  input logic clk,
  input logic rst,
  input logic halted,
  input logic mem_we
);
  // R1: the first cycle after reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!halted && !mem_we));

  // R13: halt is sticky
  p_halt_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R13: no write once stopped
  p_no_write_halted_r13: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R14: write enable is a one-cycle pulse
  p_write_pulse_r14: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

bind acc_seq_cpu acc_seq_cpu_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .halted (halted),
  .mem_we (mem_we)
);

// File: tb/acc_seq_cpu_bench.sv
module acc_seq_cpu_bench;
  localparam int MEMSZ = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] start_pc = 8'd0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, halted;
  logic       ld_en = 1'b0;
  logic [7:0] ld_addr = 8'd0, ld_data = 8'd0;
  logic       prev_we = 1'b0;

  logic [7:0] dmem [MEMSZ];
  logic [7:0] prog [MEMSZ];
  logic [7:0] refm [MEMSZ];

  int checks = 0;
  int errors = 0;
  int we_runs = 0;

  always #4 clk = ~clk;

  acc_seq_cpu u_acc_seq_cpu (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_pc  (start_pc),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  always @(posedge clk) begin
    if (ld_en) dmem[ld_addr] <= ld_data;
    else if (mem_we) dmem[mem_addr] <= mem_wdata;
    mem_rdata <= dmem[mem_addr];
  end

  always @(posedge clk) begin
    if (mem_we && prev_we) we_runs++;
    prev_we <= mem_we;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Instruction-level model of the requirements; returns halted=1 if it stops.
  task automatic ref_exec(input int spc, output bit stopped);
    int pc, steps, ea, t;
    logic [7:0] op, arg, b, r, ra, rx;
    logic z, n, c, take;
    logic [1:0] md;
    pc = spc; ra = 8'd0; rx = 8'd0; z = 0; n = 0; c = 0;
    stopped = 1'b0;
    for (steps = 0; steps < 200; steps++) begin
      if (pc > 255) begin stopped = 1'b1; return; end
      op = refm[pc];
      if (op == 8'hC0) begin stopped = 1'b1; return; end
      if (op == 8'hC8 || op == 8'hC9) begin
        rx = (op == 8'hC8) ? rx + 8'd1 : rx - 8'd1;
        z = (rx == 0); n = rx[7]; pc = pc + 1; continue;
      end
      if (op == 8'hD0 || op == 8'hD1) begin
        c = (op == 8'hD0); pc = pc + 1; continue;
      end
      if (op[7:4] == 4'hF && !op[0] && op[3:1] != 3'd0) begin
        if (pc + 1 > 255) begin stopped = 1'b1; return; end
        arg = refm[pc+1];
        case (op[3:1])
          3'd1: take = 1; 3'd2: take = !z; 3'd3: take = z; 3'd4: take = !n;
          3'd5: take = n; 3'd6: take = !c; default: take = c;
        endcase
        if (take) begin
          t = pc + 2 + $signed(arg);
          if (t < 0 || t > 255) begin stopped = 1'b1; return; end
          pc = t;
        end else pc = pc + 2;
        continue;
      end
      md = op[2:1];
      if (op[0] || md == 2'b11 || !(op[7:3] <= 5'h03 || (op[7:3] >= 5'h06 &&
          op[7:3] <= 5'h12 && op[7:3] != 5'h0E))) begin
        stopped = 1'b1; return;
      end
      if (pc + 1 > 255) begin stopped = 1'b1; return; end
      arg = refm[pc+1];
      ea = (md == 0) ? pc + 1 : (md == 1) ? int'(arg) : int'(arg) + int'(rx);
      if (ea > 255) begin stopped = 1'b1; return; end
      b = refm[ea];
      case (op[7:3])
        5'h00: begin ra = b; z = (ra == 0); n = ra[7]; end
        5'h01: refm[ea] = ra;
        5'h02: begin rx = b; z = (rx == 0); n = rx[7]; end
        5'h03: refm[ea] = rx;
        5'h06: begin ra = ra & b; z = (ra == 0); n = ra[7]; end
        5'h07: begin ra = ra | b; z = (ra == 0); n = ra[7]; end
        5'h08: begin ra = ra ^ b; z = (ra == 0); n = ra[7]; end
        5'h09: begin r = b >> 1; c = b[0]; refm[ea] = r; z = (r == 0); n = r[7]; end
        5'h0A: begin r = b << 1; c = b[7]; refm[ea] = r; z = (r == 0); n = r[7]; end
        5'h0B: begin r = {c, b[7:1]}; c = b[0]; refm[ea] = r; z = (r == 0); n = r[7]; end
        5'h0C: begin r = {b[6:0], c}; c = b[7]; refm[ea] = r; z = (r == 0); n = r[7]; end
        5'h0D: begin t = int'(ra) + int'(b) + int'(c); c = (t > 255); ra = t[7:0];
                     z = (ra == 0); n = ra[7]; end
        5'h0F: begin r = b + 8'd1; refm[ea] = r; z = (r == 0); n = r[7]; end
        5'h10: begin r = b - 8'd1; refm[ea] = r; z = (r == 0); n = r[7]; end
        5'h11: begin r = ra - b; c = (ra >= b); z = (r == 0); n = r[7]; end
        default: begin r = rx - b; c = (rx >= b); z = (r == 0); n = r[7]; end
      endcase
      pc = pc + 2;
    end
  endtask

  task automatic compare_mem(input string tag, input string what);
    int mism, first;
    mism = 0; first = 0;
    for (int i = 0; i < MEMSZ; i++)
      if (dmem[i] !== refm[i]) begin
        if (mism == 0) first = i;
        mism++;
      end
    if (mism != 0)
      chk(1'b0, tag, $sformatf("%s byte %0h", what, first), dmem[first], refm[first]);
    else
      chk(1'b1, tag, what, 0, 0);
  endtask

  task automatic run_case(input int spc, input string tag, output bit used);
    bit stopped;
    int cyc;
    for (int i = 0; i < MEMSZ; i++) refm[i] = prog[i];
    ref_exec(spc, stopped);
    used = stopped;
    if (!stopped) return;
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    for (int i = 0; i < MEMSZ; i++) begin
      ld_en = 1'b1; ld_addr = i[7:0]; ld_data = prog[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle and quiet until started
    chk(!halted && !mem_we, "R1", "idle before start", {halted, mem_we}, 0);
    start_pc = spc[7:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!halted && cyc < 6000) begin @(negedge clk); cyc++; end
    chk(halted === 1'b1, tag, "halt reached", halted, 1);
    repeat (3) @(negedge clk);
    compare_mem(tag, "final image");
    // R13: stays stopped, a new start is ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    chk(halted === 1'b1, "R13", "halt sticky", halted, 1);
    compare_mem("R13", "image after restart attempt");
  endtask

  task automatic clear_prog();
    for (int i = 0; i < MEMSZ; i++) prog[i] = 8'h00;
  endtask

  task automatic put(input int a, input logic [7:0] v);
    prog[a] = v;
  endtask

  function automatic logic [7:0] rand_op();
    logic [4:0] fams [16];
    int r;
    fams = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h06, 5'h07, 5'h08, 5'h09,
             5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h0F, 5'h10, 5'h11, 5'h12};
    r = int'($urandom % 20);
    if (r < 13) return {fams[$urandom % 16], 2'($urandom % 3), 1'b0};
    if (r == 13) return 8'hC8;
    if (r == 14) return 8'hC9;
    if (r == 15) return 8'hD0;
    if (r == 16) return 8'hD1;
    if (r == 17) return 8'hC0;
    return {4'hF, 3'(1 + $urandom % 7), 1'b0};
  endfunction

  initial begin
    bit used;
    int accepted;
    logic [7:0] op;
    void'($urandom(32'd20240611));

    // R2 R9: counted loop started away from zero
    clear_prog(); put(8'h20, 8'h03);
    put(8'h40, 8'h10); put(8'h41, 8'h05); put(8'h42, 8'h7A); put(8'h43, 8'h20);
    put(8'h44, 8'hC9); put(8'h45, 8'hF4); put(8'h46, 8'hFB); put(8'h47, 8'hC0);
    run_case(8'h40, "R2 R9 loop", used);

    // R3: immediate store/modify hits the argument byte; indexed store
    clear_prog();
    put(0, 8'h00); put(1, 8'h5A); put(2, 8'h08); put(3, 8'h00);
    put(4, 8'h10); put(5, 8'h03); put(6, 8'h0C); put(7, 8'h30);
    put(8, 8'h78); put(9, 8'h00); put(10, 8'hC0);
    run_case(0, "R3 modes", used);

    // R5 R6: add carry, rotates, shifts, dec wrap, carry branch
    clear_prog();
    put(8'h31, 8'h81); put(8'h32, 8'h02); put(8'h33, 8'h01); put(8'h34, 8'hC0);
    put(8'h00, 8'hD0); put(8'h01, 8'h00); put(8'h02, 8'hF0);
    put(8'h03, 8'h68); put(8'h04, 8'h20); put(8'h05, 8'h0A); put(8'h06, 8'h30);
    put(8'h07, 8'h62); put(8'h08, 8'h31); put(8'h09, 8'h5A); put(8'h0A, 8'h32);
    put(8'h0B, 8'h4A); put(8'h0C, 8'h33); put(8'h0D, 8'h52); put(8'h0E, 8'h34);
    put(8'h0F, 8'hFE); put(8'h10, 8'h02); put(8'h11, 8'h7A); put(8'h12, 8'h35);
    put(8'h13, 8'h82); put(8'h14, 8'h36); put(8'h15, 8'hC0);
    run_case(0, "R5 R6 arith", used);

    // R7: compares set flags without changing registers
    clear_prog(); put(8'h50, 8'h20);
    put(8'h00, 8'h00); put(8'h01, 8'h40); put(8'h02, 8'h88); put(8'h03, 8'h40);
    put(8'h04, 8'hF6); put(8'h05, 8'h02); put(8'h06, 8'h0A); put(8'h07, 8'h30);
    put(8'h08, 8'h10); put(8'h09, 8'h10); put(8'h0A, 8'h92); put(8'h0B, 8'h50);
    put(8'h0C, 8'hFC); put(8'h0D, 8'h02); put(8'h0E, 8'h1A); put(8'h0F, 8'h31);
    put(8'h10, 8'hFA); put(8'h11, 8'h02); put(8'h12, 8'h1A); put(8'h13, 8'h32);
    put(8'h14, 8'h1A); put(8'h15, 8'h33); put(8'h16, 8'h0A); put(8'h17, 8'h34);
    put(8'h18, 8'hC0);
    run_case(0, "R7 compare", used);

    // R4 R8: one-byte opcodes, carry set/clear, index wrap
    clear_prog();
    put(8'h00, 8'h00); put(8'h01, 8'hFF); put(8'h02, 8'hD0); put(8'h03, 8'hD1);
    put(8'h04, 8'h68); put(8'h05, 8'h01); put(8'h06, 8'h0A); put(8'h07, 8'h30);
    put(8'h08, 8'h10); put(8'h09, 8'hFF); put(8'h0A, 8'hC8); put(8'h0B, 8'hF6);
    put(8'h0C, 8'h01); put(8'h0D, 8'hC0); put(8'h0E, 8'hC9); put(8'h0F, 8'h1A);
    put(8'h10, 8'h31); put(8'h11, 8'hC0); put(8'h12, 8'h0A); put(8'h13, 8'h32);
    run_case(0, "R4 R8 implicit", used);

    // R10: running off the top does not wrap to 0
    clear_prog();
    put(8'h00, 8'h0A); put(8'h01, 8'h11);
    put(8'hFC, 8'h00); put(8'hFD, 8'h07); put(8'hFE, 8'h0A); put(8'hFF, 8'h10);
    run_case(8'hFC, "R10 pc runoff", used);
    clear_prog();
    put(8'h00, 8'h0A); put(8'h01, 8'h11); put(8'hFF, 8'h0A);
    run_case(8'hFF, "R10 argument beyond end", used);

    // R11: indexed sum past 255 and branch targets out of range
    clear_prog(); put(8'h10, 8'h55);
    put(0, 8'h00); put(1, 8'h77); put(2, 8'h10); put(3, 8'hF0);
    put(4, 8'h0C); put(5, 8'h20);
    run_case(0, "R11 index overflow", used);
    clear_prog();
    put(8'h00, 8'hF2); put(8'h01, 8'h80);
    put(8'h82, 8'h00); put(8'h83, 8'h99); put(8'h84, 8'h0A); put(8'h85, 8'h30);
    put(8'h86, 8'hC0);
    run_case(0, "R11 branch below zero", used);
    clear_prog();
    put(8'hF0, 8'hF2); put(8'hF1, 8'h7F);
    put(8'h71, 8'h00); put(8'h72, 8'h66); put(8'h73, 8'h0A); put(8'h74, 8'h30);
    put(8'h75, 8'hC0);
    run_case(8'hF0, "R11 branch above end", used);

    // R12: undefined opcodes stop without effects
    clear_prog();
    put(0, 8'h00); put(1, 8'h11); put(2, 8'h01); put(3, 8'h0A); put(4, 8'h30);
    run_case(0, "R12 odd opcode", used);
    clear_prog();
    put(0, 8'h00); put(1, 8'h11); put(2, 8'h0E); put(3, 8'h30);
    put(4, 8'h0A); put(5, 8'h31);
    run_case(0, "R12 mode 11", used);
    clear_prog();
    put(0, 8'h00); put(1, 8'h11); put(2, 8'hF0); put(3, 8'h02);
    put(4, 8'h0A); put(5, 8'h32);
    run_case(0, "R12 branch code F0", used);

    // Random programs against the model (R5 R6 R7 R9 mix)
    accepted = 0;
    for (int k = 0; k < 90 && accepted < 30; k++) begin
      for (int i = 0; i < MEMSZ; i++) prog[i] = 8'($urandom);
      for (int a = 0; a < 80; ) begin
        op = rand_op();
        prog[a] = op;
        if (op[7:6] == 2'b11 && op[7:4] != 4'hF) a = a + 1;
        else begin
          if (op[7:4] == 4'hF) prog[a+1] = 8'($signed(4'($urandom)));
          else if (op[2:1] == 2'b10) prog[a+1] = 8'($urandom % 160);
          else if (op[2:1] == 2'b01) prog[a+1] = 8'(96 + $urandom % 160);
          a = a + 2;
        end
      end
      prog[80] = 8'hC0;
      run_case(0, "R5 random", used);
      if (used) accepted++;
    end

    // R14: no back-to-back write enables over the whole run
    chk(we_runs == 0, "R14", "consecutive write enables", we_runs, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule